// File: doc/BRIEF.md
# Warp Branch Divergence Serializer

This block tracks the control state of one warp on a wide SIMT core at a conditional branch. All enabled lanes of a warp issue the same instruction together. A branch can leave some lanes on the taken side and others on the fall-through side. In that case the block runs the two groups as separate masked passes, one after the other, and then merges them again at a join point. If every enabled lane agrees on the branch, the warp simply moves to the chosen target and no extra pass is spent.

The issue stage reports each branch to the block. A branch report carries the per-lane condition bits, the taken target, the fall-through address and the join address. The issue stage also signals when the current pass reaches its join address. The block returns the lane enable mask and the address that the warp must fetch next. A small last-in, first-out stack holds two records for each open divergent branch: the deferred pass and the merge point. This lets branches nest inside each other. A sticky flag reports when a divergent branch arrived with no room left on the stack.

Top module: `warp_branch_serializer`

## Requirements
- R1: After reset the lane mask is all ones, the next address equals the reset address parameter (zero by default), and the overflow flag is 0.
- R2: Taken lanes are the enabled lanes whose condition bit is 1. Deferred lanes are the enabled lanes whose condition bit is 0. When both groups are non-empty and the stack has two free records, the next cycle shows the taken lanes as the mask and the taken target as the next address (default order, taken side first).
- R3: When all enabled lanes have condition 1, the next address becomes the taken target, the mask is unchanged, and the stack is not touched.
- R4: When no enabled lane has condition 1, the next address becomes the fall-through address, the mask is unchanged, and the stack is not touched.
- R5: The first join report after a split restores the deferred lanes as the mask and the fall-through address as the next address.
- R6: The second join report after a split restores the mask held before the branch and sets the next address to the join address.
- R7: Splits nest in last-in, first-out order: an inner split rejoins completely before the outer deferred pass starts.
- R8: A join report while the stack is empty changes neither the mask nor the next address.
- R9: A divergent branch that finds fewer than two free stack records sets the overflow flag and leaves the mask, the address and the stack as they were. The flag then stays 1 until reset.
- R10: When a branch report and a join report arrive in the same cycle, the join is carried out and the branch is discarded.
- R11: A branch never turns on a lane that was disabled before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| br_vld_i | input | 1 | Branch report strobe |
| br_pred_i | input | LANES | Per-lane branch condition |
| br_taken_pc_i | input | PC_W | Taken target address |
| br_fall_pc_i | input | PC_W | Fall-through address |
| br_join_pc_i | input | PC_W | Join address for the split passes |
| join_vld_i | input | 1 | Current pass reached its join address |
| act_mask_o | output | LANES | Lane enable mask |
| next_pc_o | output | PC_W | Address the warp fetches next |
| ovf_o | output | 1 | Sticky stack overflow flag |

## Verification
Two functions can fall in the same cycle: a branch report and a join report. The bench creates this case by opening a split and then raising both strobes together, with a condition vector that would split the warp again. It judges the result by whether the outputs match the deferred pass restored from the stack, with no trace of the discarded branch. This includes the later full rejoin. A second collision arises when a divergent branch meets a full stack. The bench fills the stack with two nested splits, sends a third divergent branch, and checks that the flag rises while the mask and the address stay unchanged.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   // What the controller does with the warp state in a given cycle.
   typedef enum logic [2:0] {
      WB_IDLE  = 3'd0,
      WB_JOIN  = 3'd1,
      WB_TAKE  = 3'd2,
      WB_FALL  = 3'd3,
      WB_SPLIT = 3'd4,
      WB_OVF   = 3'd5
   } wb_act_e;

endpackage

// File: rtl/wbs_split_unit.sv
module wbs_split_unit #(
   parameter int LANES       = 32,
   parameter int PC_W        = 32,
   parameter bit TAKEN_FIRST = 1'b1
) (
   input  logic [LANES-1:0] act_mask_i,
   input  logic [LANES-1:0] pred_i,
   input  logic [PC_W-1:0]  taken_pc_i,
   input  logic [PC_W-1:0]  fall_pc_i,
   output logic [LANES-1:0] first_mask_o,
   output logic [PC_W-1:0]  first_pc_o,
   output logic [LANES-1:0] defer_mask_o,
   output logic [PC_W-1:0]  defer_pc_o,
   output logic             diverge_o,
   output logic             any_taken_o
);

   logic [LANES-1:0] tk_mask;
   logic [LANES-1:0] nt_mask;

   assign tk_mask     = act_mask_i & pred_i;
   assign nt_mask     = act_mask_i & ~pred_i;
   assign any_taken_o = |tk_mask;
   assign diverge_o   = (|tk_mask) && (|nt_mask);

   // Pass order is a build-time option.
   generate
      if (TAKEN_FIRST) begin : g_taken_first
         assign first_mask_o = tk_mask;
         assign first_pc_o   = taken_pc_i;
         assign defer_mask_o = nt_mask;
         assign defer_pc_o   = fall_pc_i;
      end else begin : g_fall_first
         assign first_mask_o = nt_mask;
         assign first_pc_o   = fall_pc_i;
         assign defer_mask_o = tk_mask;
         assign defer_pc_o   = taken_pc_i;
      end
   endgenerate

endmodule

// File: rtl/wbs_recon_stack.sv
module wbs_recon_stack #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push2_i,
   input  logic [W-1:0] lo_data_i,
   input  logic [W-1:0] hi_data_i,
   input  logic         pop_i,
   output logic [W-1:0] top_o,
   output logic         empty_o,
   output logic         room2_o
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  slot_q [DEPTH];
   logic [CW-1:0] cnt_q;
   logic [CW:0]   cnt_x;

   assign cnt_x   = {1'b0, cnt_q};
   assign empty_o = (cnt_q == '0);
   assign room2_o = (cnt_x + (CW+1)'(2)) <= (CW+1)'(DEPTH);
   assign top_o   = slot_q[IW'(cnt_q - CW'(1))];

   // A push2 writes the merge record first and the deferred record above it.
   always_ff @(posedge clk_i) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push2_i && (cnt_x == (CW+1)'(i)))
            slot_q[i] <= lo_data_i;
         else if (push2_i && ((cnt_x + (CW+1)'(1)) == (CW+1)'(i)))
            slot_q[i] <= hi_data_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (push2_i)
         cnt_q <= cnt_q + CW'(2);
      else if (pop_i && !empty_o)
         cnt_q <= cnt_q - CW'(1);
   end

endmodule

// File: rtl/warp_branch_serializer.sv
module warp_branch_serializer #(
   parameter int              LANES       = 32,
   parameter int              PC_W        = 32,
   parameter int              DEPTH       = 8,
   parameter bit              TAKEN_FIRST = 1'b1,
   parameter logic [PC_W-1:0] RST_PC      = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             br_vld_i,
   input  logic [LANES-1:0] br_pred_i,
   input  logic [PC_W-1:0]  br_taken_pc_i,
   input  logic [PC_W-1:0]  br_fall_pc_i,
   input  logic [PC_W-1:0]  br_join_pc_i,
   input  logic             join_vld_i,
   output logic [LANES-1:0] act_mask_o,
   output logic [PC_W-1:0]  next_pc_o,
   output logic             ovf_o
);
   import wbs_pkg::*;

   localparam int EW = LANES + PC_W;

   // Elaboration-time parameter checks.
   if (LANES < 2) begin : g_bad_lanes
      $error("warp_branch_serializer: LANES must be at least 2");
   end
   if (PC_W < 1) begin : g_bad_pcw
      $error("warp_branch_serializer: PC_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("warp_branch_serializer: DEPTH must hold one split (2 records)");
   end

   logic [LANES-1:0] mask_q;
   logic [PC_W-1:0]  pc_q;
   logic             ovf_q;

   logic [LANES-1:0] first_mask, defer_mask;
   logic [PC_W-1:0]  first_pc, defer_pc;
   logic             diverge, any_taken;
   logic [EW-1:0]    top_rec;
   logic             stk_empty, stk_room2;
   wb_act_e          act;

   wbs_split_unit #(
      .LANES      (LANES),
      .PC_W       (PC_W),
      .TAKEN_FIRST(TAKEN_FIRST)
   ) u_split (
      .act_mask_i  (mask_q),
      .pred_i      (br_pred_i),
      .taken_pc_i  (br_taken_pc_i),
      .fall_pc_i   (br_fall_pc_i),
      .first_mask_o(first_mask),
      .first_pc_o  (first_pc),
      .defer_mask_o(defer_mask),
      .defer_pc_o  (defer_pc),
      .diverge_o   (diverge),
      .any_taken_o (any_taken)
   );

   // Join has priority; a branch in the same cycle is discarded.
   always_comb begin
      act = WB_IDLE;
      if (join_vld_i) begin
         if (!stk_empty) act = WB_JOIN;
      end else if (br_vld_i) begin
         if (diverge)        act = stk_room2 ? WB_SPLIT : WB_OVF;
         else if (any_taken) act = WB_TAKE;
         else                act = WB_FALL;
      end
   end

   wbs_recon_stack #(
      .W    (EW),
      .DEPTH(DEPTH)
   ) u_stack (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push2_i  (act == WB_SPLIT),
      .lo_data_i({mask_q, br_join_pc_i}),
      .hi_data_i({defer_mask, defer_pc}),
      .pop_i    (act == WB_JOIN),
      .top_o    (top_rec),
      .empty_o  (stk_empty),
      .room2_o  (stk_room2)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         mask_q <= '1;
         pc_q   <= RST_PC;
         ovf_q  <= 1'b0;
      end else begin
         unique case (act)
            WB_JOIN: begin
               mask_q <= top_rec[EW-1:PC_W];
               pc_q   <= top_rec[PC_W-1:0];
            end
            WB_SPLIT: begin
               mask_q <= first_mask;
               pc_q   <= first_pc;
            end
            WB_TAKE: pc_q  <= br_taken_pc_i;
            WB_FALL: pc_q  <= br_fall_pc_i;
            WB_OVF:  ovf_q <= 1'b1;
            default: ;
         endcase
      end
   end

   assign act_mask_o = mask_q;
   assign next_pc_o  = pc_q;
   assign ovf_o      = ovf_q;

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
   parameter int LANES       = 32,
   parameter int PC_W        = 32,
   parameter bit TAKEN_FIRST = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             br_vld_i,
   input logic [LANES-1:0] br_pred_i,
   input logic [PC_W-1:0]  br_taken_pc_i,
   input logic [PC_W-1:0]  br_fall_pc_i,
   input logic [PC_W-1:0]  br_join_pc_i,
   input logic             join_vld_i,
   input logic [LANES-1:0] act_mask_o,
   input logic [PC_W-1:0]  next_pc_o,
   input logic             ovf_o
);

   logic [LANES-1:0] tk, nt, first;
   logic             br_only;

   assign tk      = act_mask_o & br_pred_i;
   assign nt      = act_mask_o & ~br_pred_i;
   assign first   = TAKEN_FIRST ? tk : nt;
   assign br_only = br_vld_i && !join_vld_i;

   p_split_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_only && (tk != '0) && (nt != '0)) |=>
         ((act_mask_o == $past(first)) ||
          (ovf_o && (act_mask_o == $past(act_mask_o)))));

   p_uniform_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_only && (tk != '0) && (nt == '0)) |=>
         ($stable(act_mask_o) && (next_pc_o == $past(br_taken_pc_i))));

   p_all_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_only && (tk == '0)) |=>
         ($stable(act_mask_o) && (next_pc_o == $past(br_fall_pc_i))));

   p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o);

   p_ovf_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o) |-> ($stable(act_mask_o) && $stable(next_pc_o)));

   p_no_new_lane_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      br_only |=> ((act_mask_o & ~$past(act_mask_o)) == '0));

endmodule

bind warp_branch_serializer wbs_checker #(
   .LANES      (LANES),
   .PC_W       (PC_W),
   .TAKEN_FIRST(TAKEN_FIRST)
) u_chk (.*);

// File: tb/sim_warp_branch_serializer.sv
module sim_warp_branch_serializer;

   localparam int L  = 32;
   localparam int P  = 32;
   localparam int DP = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         br_vld = 1'b0;
   logic [L-1:0] br_pred = '0;
   logic [P-1:0] tpc = '0, fpc = '0, jpc = '0;
   logic         jn_vld = 1'b0;
   logic [L-1:0] act_mask;
   logic [P-1:0] next_pc;
   logic         ovf;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   // Reference model state.
   logic [L-1:0]   m_mask;
   logic [P-1:0]   m_pc;
   bit             m_ovf;
   logic [L+P-1:0] stk[$];

   always #4 clk = ~clk;

   warp_branch_serializer #(.LANES(L), .PC_W(P), .DEPTH(DP)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .br_vld_i(br_vld), .br_pred_i(br_pred),
      .br_taken_pc_i(tpc), .br_fall_pc_i(fpc), .br_join_pc_i(jpc),
      .join_vld_i(jn_vld), .act_mask_o(act_mask), .next_pc_o(next_pc),
      .ovf_o(ovf));

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "mask", 64'(act_mask), 64'(m_mask));
      chk(tag, "pc",   64'(next_pc),  64'(m_pc));
      chk(tag, "ovf",  64'(ovf),      64'(m_ovf));
   endtask

   // Called at a falling edge: drive, advance model, compare after the edge.
   task automatic step(input bit br, input logic [L-1:0] pr,
                       input logic [P-1:0] t, input logic [P-1:0] f,
                       input logic [P-1:0] r, input bit jn, input string tag);
      logic [L-1:0]   tk, nt;
      logic [L+P-1:0] e;
      br_vld = br; br_pred = pr; tpc = t; fpc = f; jpc = r; jn_vld = jn;
      tk = m_mask & pr;
      nt = m_mask & ~pr;
      if (jn) begin
         if (stk.size() > 0) begin
            e = stk.pop_back();
            m_mask = e[L+P-1:P];
            m_pc   = e[P-1:0];
         end
      end else if (br) begin
         if (tk != '0 && nt != '0) begin
            if (stk.size() + 2 > DP) m_ovf = 1'b1;
            else begin
               stk.push_back({m_mask, r});
               stk.push_back({nt, f});
               m_mask = tk;
               m_pc   = t;
            end
         end else if (tk != '0) m_pc = t;
         else m_pc = f;
      end
      @(posedge clk);
      #2;
      compare(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step(1'b0, '0, '0, '0, '0, 1'b0, tag);
   endtask

   task automatic join1(input string tag);
      step(1'b0, '0, '0, '0, '0, 1'b1, tag);
   endtask

   initial begin
      m_mask = '1; m_pc = '0; m_ovf = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset");
      idle("R1 hold");

      // Lanes 0..2 versus lanes 3..31.
      step(1'b1, 32'hFFFF_FFF8, 32'h100, 32'h104, 32'h200, 1'b0, "R2 split");
      join1("R5 deferred pass");
      join1("R6 rejoin");

      step(1'b1, 32'hFFFF_FFFF, 32'h300, 32'h304, 32'h0, 1'b0, "R3 uniform taken");
      step(1'b1, 32'h0000_0000, 32'h400, 32'h404, 32'h0, 1'b0, "R4 all fall");
      join1("R8 empty join");
      join1("R8 empty join again");

      // Nested split.
      step(1'b1, 32'h0000_FFFF, 32'h500, 32'h504, 32'h5F0, 1'b0, "R7 outer split");
      step(1'b1, 32'h00FF_00FF, 32'h600, 32'h604, 32'h6F0, 1'b0, "R7 inner split");
      step(1'b1, 32'h0000_00FF, 32'h610, 32'h614, 32'h0,   1'b0, "R3 uniform inside");
      join1("R7 inner deferred");
      join1("R7 inner rejoin");
      join1("R7 outer deferred");
      join1("R7 outer rejoin");

      // Branch and join together.
      step(1'b1, 32'h0000_000F, 32'h700, 32'h704, 32'h7F0, 1'b0, "R10 open split");
      step(1'b1, 32'h0000_0003, 32'h710, 32'h714, 32'h7E0, 1'b1, "R10 collision");
      join1("R10 rejoin");
      idle("R10 settle");

      // Overflow with two records per split and DP=4.
      step(1'b1, 32'hFFFF_0000, 32'h800, 32'h804, 32'h8F0, 1'b0, "R9 fill 1");
      step(1'b1, 32'hFF00_0000, 32'h900, 32'h904, 32'h9F0, 1'b0, "R9 fill 2");
      step(1'b1, 32'hF000_0000, 32'hA00, 32'hA04, 32'hAF0, 1'b0, "R9 overflow");
      join1("R9 pop 1");
      join1("R9 pop 2");
      join1("R9 pop 3");
      join1("R9 pop 4 sticky");
      step(1'b1, 32'h0000_0000, 32'hB00, 32'hB04, 32'h0, 1'b0, "R11 fall keeps mask");

      // Mixed traffic checked against the model every cycle.
      for (int i = 0; i < 300; i++) begin
         int          sel;
         logic [L-1:0] pr;
         sel = int'($urandom_range(0, 9));
         case (int'($urandom_range(0, 3)))
            0: pr = '0;
            1: pr = '1;
            2: pr = L'(32'hFFFF_FFFF << $urandom_range(1, 31));
            default: pr = L'($urandom);
         endcase
         step(sel < 5, pr, P'($urandom), P'($urandom), P'($urandom),
              (sel >= 4 && sel < 8), "R2 R7 R10 mixed");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule